// File: doc/BRIEF.md
# Two-Phase Toggle-Handshake Pipeline Chain

This block is a clocked model of a ripple buffer built from identical stages that talk with two-phase, single-rail, bundled-data handshakes. A stage signals an event by flipping the level of a wire. A rising edge and a falling edge mean the same thing. Each stage holds a one-bit request register and a data register. The stage's acknowledge to its predecessor is its own request register, so taking an item from the left and offering it to the right happen as one event. A stage is full while its request level differs from the acknowledge that comes back from its right neighbour. It is empty once the two levels match.

A producer offers an item by placing it on `inData` and flipping `inReq`. It may offer the next item once `inAck` matches `inReq` again. A consumer sees a valid item whenever `outReq` differs from `outAck`, and it takes the item by flipping `outAck`. Because fullness is decided by comparing levels and not by alternating tokens, a stalled chain holds one item in every stage. The block also reports a per-stage occupancy vector and the total item count.

Top module: `toggle_chain`

## Requirements
- R1: While reset is asserted and after it is released, all request registers are 0. With `inReq` and `outAck` held at 0, this gives `inAck`=0, `outReq`=0, `cellFull`=0 and `itemCount`=0.
- R2: Stage k captures on a clock edge only when its incoming request level differs from its own request level and the stage is empty. On that edge its request register takes the incoming level and its data register loads the incoming data. A stage captures at most one item per clock.
- R3: Bit k of `cellFull` is 1 exactly when the request level of stage k (bit 0 is the stage nearest the producer) differs from the acknowledge level returned to it. The last stage's returned acknowledge is `outAck`.
- R4: `inAck` is the request level of stage 0. It equals `inReq` once the offered item has been taken.
- R5: When the consumer stalls and the producer keeps offering, the chain fills until every bit of `cellFull` is 1 and `itemCount` equals DEPTH. The producer's next offer then stays pending (`inAck` differs from `inReq`), and the data in a full stage does not change.
- R6: Items leave in the order they entered, with none lost and none duplicated.
- R7: Both polarities of a toggle carry the same meaning. Alternate items travel on rising and falling request edges and are delivered alike.
- R8: In an empty chain, an item offered before edge 1 appears at `outReq` after edge DEPTH. After edge e it occupies stage e-1.
- R9: An offer taken at the input and an item removed at the output in the same cycle leave `itemCount` unchanged. In general, the count moves by the number taken in minus the number removed.
- R10: `itemCount` equals the number of 1 bits in `cellFull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inReq | input | 1 | Producer request toggle |
| inData | input | DATA_W | Producer data, held while an offer is pending |
| inAck | output | 1 | Acknowledge toggle back to the producer |
| outReq | output | 1 | Request toggle to the consumer |
| outData | output | DATA_W | Data of the last stage |
| outAck | input | 1 | Consumer acknowledge toggle |
| cellFull | output | DEPTH | Per-stage occupancy, bit 0 nearest the producer |
| itemCount | output | $clog2(DEPTH+1) | Number of occupied stages |

## Verification
An input capture by stage 0 and a removal at the output can fall in the same cycle. The same holds for an output removal and an internal ripple. The bench provokes this by running the producer and the consumer at full rate, and then with independent random stalls. Every cycle it samples the count before driving and predicts the next count from the input capture it sees on `inAck` and the removal it made itself. A cycle that contains both events is judged against an unchanged count.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef struct packed {
    logic load;
  } cellStrobe_t;
endpackage

// File: rtl/tc_cell_ctrl.sv
module tc_cell_ctrl
  import tc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqIn,
  input  logic        ackIn,
  output logic        reqOut,
  output logic        full,
  output cellStrobe_t strobe
);
  logic reqQ;

  assign full        = reqQ ^ ackIn;
  assign strobe.load = (reqIn ^ reqQ) & ~full;
  assign reqOut      = reqQ;

  always_ff @(posedge clk) begin
    if (!rstN) reqQ <= 1'b0;
    else if (strobe.load) reqQ <= reqIn;
  end

  // R2: a full stage never advances its request level
  assert_hold_when_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    full |=> $stable(reqOut));
endmodule

// File: rtl/tc_cell_data.sv
module tc_cell_data
  import tc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cellStrobe_t       strobe,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);
  always_ff @(posedge clk) begin
    if (!rstN) dOut <= '0;
    else if (strobe.load) dOut <= dIn;
  end
endmodule

// File: rtl/tc_occupancy.sv
module tc_occupancy #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] cellFull,
  output logic [CNT_W-1:0] itemCount
);
  always_comb begin
    itemCount = '0;
    for (int k = 0; k < DEPTH; k++) itemCount = itemCount + CNT_W'(cellFull[k]);
  end
endmodule

// File: rtl/toggle_chain.sv
module toggle_chain
  import tc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inReq,
  input  logic [DATA_W-1:0] inData,
  output logic              inAck,
  output logic              outReq,
  output logic [DATA_W-1:0] outData,
  input  logic              outAck,
  output logic [DEPTH-1:0]  cellFull,
  output logic [CNT_W-1:0]  itemCount
);
  logic [DEPTH:0]    reqChain;
  logic [DEPTH-1:0]  ackIn;
  logic [DATA_W-1:0] dataChain [DEPTH+1];
  cellStrobe_t       strobe    [DEPTH];

  assign reqChain[0]  = inReq;
  assign dataChain[0] = inData;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    if (i == DEPTH - 1) begin : g_last
      assign ackIn[i] = outAck;
    end else begin : g_mid
      assign ackIn[i] = reqChain[i+2];
    end

    tc_cell_ctrl u_ctrl (
      .clk(clk), .rstN(rstN),
      .reqIn(reqChain[i]), .ackIn(ackIn[i]),
      .reqOut(reqChain[i+1]), .full(cellFull[i]), .strobe(strobe[i])
    );

    tc_cell_data #(.DATA_W(DATA_W)) u_data (
      .clk(clk), .rstN(rstN), .strobe(strobe[i]),
      .dIn(dataChain[i]), .dOut(dataChain[i+1])
    );

    // R5: a full stage keeps its data
    assert_full_data_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
      cellFull[i] |=> $stable(dataChain[i+1]));

    if (i > 0) begin : g_ripple
      // R6: a capture copies the left neighbour's data
      assert_ripple_data_R6: assert property (@(posedge clk) disable iff (!rstN)
        strobe[i].load |=> dataChain[i+1] == $past(dataChain[i]));
    end
    if (i < DEPTH - 1) begin : g_excl
      // R2: neighbours never capture on the same edge
      assert_neighbour_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
        strobe[i].load |-> !strobe[i+1].load);
    end
  end

  assign inAck   = reqChain[1];
  assign outReq  = reqChain[DEPTH];
  assign outData = dataChain[DEPTH];

  tc_occupancy #(.DEPTH(DEPTH)) u_occ (.cellFull(cellFull), .itemCount(itemCount));

  // R9: occupancy moves by at most one per cycle
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (int'(itemCount) <= int'($past(itemCount)) + 1) &&
    (int'(itemCount) + 1 >= int'($past(itemCount))));
endmodule

// File: tb/toggle_chain_bench.sv
module toggle_chain_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 4;
  localparam int CW = $clog2(N + 1);
  localparam int TOTAL = 200;

  logic clk = 0, rstN = 0, inReq = 0, outAck = 0;
  logic [W-1:0] inData = '0;
  logic inAck, outReq;
  logic [W-1:0] outData;
  logic [N-1:0] cellFull;
  logic [CW-1:0] itemCount;

  int compared = 0, mismatched = 0;
  int txNext = 0, rxNext = 0, prevCount = 0;
  bit tracking = 0, prevInAck = 0, popDid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  toggle_chain #(.DATA_W(W), .DEPTH(N)) u_toggle_chain (
    .clk(clk), .rstN(rstN), .inReq(inReq), .inData(inData), .inAck(inAck),
    .outReq(outReq), .outData(outData), .outAck(outAck),
    .cellFull(cellFull), .itemCount(itemCount));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic step(input bit allowPush, input bit allowPop);
    bit pushed;
    @(negedge clk);
    pushed = (inAck != prevInAck);
    if (tracking) begin
      if (pushed && popDid)
        check(int'(itemCount) == prevCount, "R9 same-cycle push/pop", int'(itemCount), prevCount);
      else
        check(int'(itemCount) == prevCount + int'(pushed) - int'(popDid), "R9 count flow",
              int'(itemCount), prevCount + int'(pushed) - int'(popDid));
      if (pushed) check(inAck == inReq, "R4 ack matches request", int'(inAck), int'(inReq));
    end
    check(int'(itemCount) == $countones(cellFull), "R10 count vs vector", int'(itemCount), $countones(cellFull));
    tracking = 1;
    prevCount = int'(itemCount);
    prevInAck = inAck;
    popDid = 0;
    if (outReq != outAck) begin
      check(int'(outData) == (rxNext % 256), "R6 R7 order", int'(outData), rxNext % 256);
      if (allowPop) begin
        outAck = ~outAck;
        rxNext++;
        popDid = 1;
      end
    end
    if (inAck == inReq && txNext < TOTAL && allowPush) begin
      inData = W'(txNext);
      inReq = ~inReq;
      txNext++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(int'(itemCount) == 0 && cellFull == 0, "R1 reset empty", int'(itemCount), 0);
    check(inAck == 0 && outReq == 0, "R1 reset toggles", int'({inAck, outReq}), 0);
    rstN = 1;
    @(negedge clk);
    check(int'(itemCount) == 0 && cellFull == 0, "R1 after release", int'(cellFull), 0);

    // R8 latency / R2 R3 position of a lone item
    inData = 8'd0; inReq = 1; txNext = 1;
    for (int e = 1; e <= N; e++) begin
      @(negedge clk);
      check(cellFull == N'(1) << (e - 1), "R2 R3 item position", int'(cellFull), 1 << (e - 1));
      if (e < N) check(outReq == 0, "R8 not yet out", int'(outReq), 0);
      else check(outReq == 1, "R8 out after DEPTH edges", int'(outReq), 1);
      if (e == 1) check(inAck == 1, "R4 ack after capture", int'(inAck), 1);
    end
    check(outData == 8'd0, "R6 first item", int'(outData), 0);
    outAck = 1; rxNext = 1;

    // R5 fill with stalled consumer
    for (int c = 0; c < 3 * N + 4; c++) step(1, 0);
    @(negedge clk);
    check(cellFull == '1, "R5 all stages full", int'(cellFull), (1 << N) - 1);
    check(int'(itemCount) == N, "R5 holds DEPTH items", int'(itemCount), N);
    check(inAck != inReq, "R5 next offer pending", int'(inAck), int'(~inReq));
    tracking = 0;

    // full-rate both sides, then random stalls
    for (int c = 0; c < 60; c++) step(1, 1);
    for (int c = 0; c < 20000 && rxNext < TOTAL; c++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);
    for (int c = 0; c < 3 * N; c++) step(0, 1);
    check(rxNext == TOTAL, "R6 no loss", rxNext, TOTAL);
    check(int'(itemCount) == 0, "R6 no duplicate left", int'(itemCount), 0);
    finish_run();
  end
endmodule